// File: doc/BRIEF.md
# Pulse Accumulator with Gated Time Mode

This block is a 16-bit pulse accumulator. It watches the pin that also feeds timer capture channel 7. In event mode it counts the selected transitions on that pin. In gated mode it counts ticks of a clock divided by 64 for as long as the pin stays at its active level. The block has its own enable and does not depend on the main timer enable.

Software uses a byte-wide register port with four addresses. Address 0 is the control register. Address 1 holds the two flags. Address 2 is the count high byte and address 3 is the count low byte. Reading the high byte captures the low byte, so a 16-bit value can be read coherently. Writing the high byte stages it, and writing the low byte then loads the whole count at once. An interrupt request output combines each flag with its enable bit.

A parameter marks whether channel 7 exists. When it does not, the control register is reserved: it reads as zero and ignores writes, so the accumulator never runs.

Top module: `pulse_accum`

## Requirements
- R1: Control register (address 0) fields: bit 6 enable, bit 5 mode (0 event, 1 gated), bit 4 polarity, bits 3:2 clock select (stored, read back, no effect), bit 1 overflow interrupt enable, bit 0 input interrupt enable. Bit 7 always reads 0. Control, count, flags and irq are all 0 after reset.
- R2: While enable is 0, the count holds and neither flag is set by the pin, in either mode.
- R3: In event mode the count increments once per selected edge of the pin: rising when polarity is 1, falling when polarity is 0. The pin passes through a 2-stage synchronizer, so the new count is visible 3 clock edges after the pin changes.
- R4: In gated mode the count increments on each tick of a free-running divide-by-64 prescaler, while the synchronized pin is at the active level: high when polarity is 0, low when polarity is 1.
- R5: The input flag (address 1, bit 0) is set by each counted edge in event mode. In gated mode it is set by the trailing edge of the gate, that is, the transition out of the active level.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (address 1, bit 1).
- R7: Writing 1 to a flag bit at address 1 clears that flag, and writing 0 leaves it unchanged. When a set and a clear happen in the same cycle, the flag ends up set.
- R8: Writing address 2 stages the high byte. Writing address 3 then loads {staged high, written low} into the count. A load wins over an increment in the same cycle.
- R9: Reading address 2 returns the live high byte and captures the low byte. Reading address 3 returns that captured low byte, even if the count has moved since.
- R10: irq = (overflow flag AND bit 1) OR (input flag AND bit 0).
- R11: With HAS_CH7 = 0, the control register reads 0, ignores writes, and the accumulator never counts or raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Shared channel-7 pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is an overflow wrap and a software write that clears the overflow flag. The second pair is a counted edge and a write of the count low byte. The bench provokes each collision by counting the synchronizer delay: it raises the pin and then issues the register write exactly on the third edge, the one where the increment lands. It then reads the result back through the port. The flag must still be set, and the count must equal the loaded value rather than the loaded value plus one.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

   // Register addresses on the byte port
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_FLAG = 2'd1;
   localparam logic [1:0] ADDR_CNTH = 2'd2;
   localparam logic [1:0] ADDR_CNTL = 2'd3;

   // Flag bit positions at ADDR_FLAG
   localparam int FLAG_IN_BIT  = 0;
   localparam int FLAG_OVF_BIT = 1;

   // Control register image, MSB first
   typedef struct packed {
      logic       rsvd;
      logic       en;
      logic       gated;
      logic       pol;
      logic [1:0] clk_sel;
      logic       ovf_ie;
      logic       in_ie;
   } pacc_ctrl_t;

   localparam logic [7:0] CTRL_WR_MASK = 8'h7F;

endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic pol_i,
   output logic level_o,
   output logic edge_o
);

   localparam int SH_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pacc_sync_edge: STAGES must be at least 2");
   end

   logic [SH_W-1:0] sh_q;
   logic            prev;
   logic            rise;
   logic            fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else begin
         sh_q <= {sh_q[SH_W-2:0], pin_i};
      end
   end

   assign level_o = sh_q[STAGES-1];
   assign prev    = sh_q[STAGES];
   assign rise    = level_o & ~prev;
   assign fall    = ~level_o & prev;

   // polarity 1 selects rising, 0 selects falling; in gated mode the same
   // choice is exactly the trailing edge of the active level
   assign edge_o  = pol_i ? rise : fall;

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o) else $error("edge pulse longer than one cycle"); // R3

endmodule

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   localparam int  PS_W   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit  IS_POW = ((DIV & (DIV - 1)) == 0);
   localparam logic [PS_W-1:0] LAST = PS_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("pacc_prescaler: DIV must be at least 2");
   end

   logic [PS_W-1:0] ps_q;

   if (IS_POW) begin : g_pow2
      // power of two: counter wraps naturally, tick on all ones
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ps_q <= '0;
         else        ps_q <= ps_q + 1'b1;
      end
      assign tick_o = &ps_q;
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ps_q <= '0;
         else if (ps_q == LAST) ps_q <= '0;
         else                   ps_q <= ps_q + 1'b1;
      end
      assign tick_o = (ps_q == LAST);
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o) else $error("prescaler ticks back to back"); // R4

endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = inc_i & ~load_i & (cnt_q == CNT_MAX);

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && cnt_q == CNT_MAX) |=> (cnt_q == '0)) else $error("wrap did not reach zero"); // R6

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i))) else $error("load lost to increment"); // R8

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
   import pacc_pkg::*;
#(
   parameter bit HAS_CH7     = 1'b1,
   parameter int CNT_W       = 16,
   parameter int DIV         = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_in,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq
);

   localparam int HI_W = CNT_W - 8;

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("pulse_accum: CNT_W must be 9..16");
   end

   // ---------------- register port decode ----------------
   logic wr_ctrl, wr_flag, wr_hi, wr_load, rd_hi;
   assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
   assign wr_flag = wr_en && (addr == ADDR_FLAG);
   assign wr_hi   = wr_en && (addr == ADDR_CNTH);
   assign wr_load = wr_en && (addr == ADDR_CNTL);
   assign rd_hi   = rd_en && (addr == ADDR_CNTH);

   // ---------------- control register ----------------
   pacc_ctrl_t ctrl_q;

   if (HAS_CH7) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ctrl_q <= '0;
         else if (wr_ctrl) ctrl_q <= pacc_ctrl_t'(wdata & CTRL_WR_MASK);
      end
   end else begin : g_ctrl_rsvd
      assign ctrl_q = '0;
   end

   // ---------------- input path ----------------
   logic level, sel_edge, tick;

   pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .pol_i  (ctrl_q.pol),
      .level_o(level),
      .edge_o (sel_edge)
   );

   pacc_prescaler #(.DIV(DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick_o(tick)
   );

   logic gate_act, inc, in_evt;
   assign gate_act = level ^ ctrl_q.pol;
   assign inc      = ctrl_q.en & (ctrl_q.gated ? (tick & gate_act) : sel_edge);
   assign in_evt   = ctrl_q.en & sel_edge;

   // ---------------- count with staged byte access ----------------
   logic [HI_W-1:0]  wbuf_q;
   logic [7:0]       rbuf_q;
   logic [CNT_W-1:0] cnt;
   logic             wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbuf_q <= '0;
         rbuf_q <= '0;
      end else begin
         if (wr_hi) wbuf_q <= wdata[HI_W-1:0];
         if (rd_hi) rbuf_q <= cnt[7:0];
      end
   end

   pacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (wr_load),
      .load_val_i({wbuf_q, wdata}),
      .inc_i     (inc),
      .cnt_o     (cnt),
      .wrap_o    (wrap)
   );

   // ---------------- flags: write-one-to-clear, set wins ----------------
   logic ovf_q, inf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         inf_q <= 1'b0;
      end else begin
         ovf_q <= (ovf_q & ~(wr_flag & wdata[FLAG_OVF_BIT])) | wrap;
         inf_q <= (inf_q & ~(wr_flag & wdata[FLAG_IN_BIT]))  | in_evt;
      end
   end

   assign irq = (ovf_q & ctrl_q.ovf_ie) | (inf_q & ctrl_q.in_ie);

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_CTRL: rdata = {1'b0, ctrl_q[6:0]};
         ADDR_FLAG: begin
            rdata[FLAG_OVF_BIT] = ovf_q;
            rdata[FLAG_IN_BIT]  = inf_q;
         end
         ADDR_CNTH: rdata[HI_W-1:0] = cnt[CNT_W-1:8];
         default:   rdata = rbuf_q;
      endcase
   end

   // ---------------- assertions ----------------
   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !wr_load) |=> $stable(cnt)) else $error("count moved while disabled"); // R2

   AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q) else $error("overflow flag lost"); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.ovf_ie && !ctrl_q.in_ie) |-> !irq) else $error("irq without enable"); // R10

   if (!HAS_CH7) begin : g_rsvd_chk
      AST_NO_CH7_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_load |=> $stable(cnt)) else $error("counting without channel 7"); // R11
   end

endmodule

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata, rdata_nc;
   logic       irq, irq_nc;

   always #4 clk = ~clk;

   pulse_accum u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   pulse_accum #(.HAS_CH7(1'b0)) u_dut_nc (
      .clk(clk), .rst_n(rst_n), .pin_in(pin), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata_nc), .irq(irq_nc)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit        m_s1, m_s2, m_prev;
   int        m_ps;
   bit [7:0]  m_ctrl;
   bit [15:0] m_cnt;
   bit [7:0]  m_wbuf, m_rbuf;
   bit        m_ovf, m_inf;

   always @(posedge clk) begin
      bit en, md, pol, sel, tk, act, inc, ld, wrp;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_ps = 0; m_ctrl = 0; m_cnt = 0;
         m_wbuf = 0; m_rbuf = 0; m_ovf = 0; m_inf = 0;
      end else begin
         en  = m_ctrl[6];
         md  = m_ctrl[5];
         pol = m_ctrl[4];
         sel = pol ? (m_s2 && !m_prev) : (!m_s2 && m_prev);
         tk  = (m_ps == 63);
         act = m_s2 ^ pol;
         inc = en && (md ? (tk && act) : sel);
         ld  = wr_en && addr == 2'd3;
         wrp = inc && !ld && m_cnt == 16'hFFFF;
         if (rd_en && addr == 2'd2) m_rbuf = m_cnt[7:0];
         if (ld) m_cnt = {m_wbuf, wdata};
         else if (inc) m_cnt = m_cnt + 16'd1;
         if (wr_en && addr == 2'd2) m_wbuf = wdata;
         if (wr_en && addr == 2'd1) begin
            if (wdata[1]) m_ovf = 0;
            if (wdata[0]) m_inf = 0;
         end
         if (wrp) m_ovf = 1;
         if (en && sel) m_inf = 1;
         if (wr_en && addr == 2'd0) m_ctrl = wdata & 8'h7F;
         m_prev = m_s2;
         m_s2 = m_s1;
         m_s1 = pin;
         m_ps = tk ? 0 : m_ps + 1;
      end
   end

   function automatic logic [7:0] m_read(logic [1:0] a);
      case (a)
         2'd0:    return m_ctrl;
         2'd1:    return {6'd0, m_ovf, m_inf};
         2'd2:    return m_cnt[15:8];
         default: return m_rbuf;
      endcase
   endfunction

   // per-cycle comparison, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rst_n && !done) begin
            chk("R10 irq vs model", {15'd0, irq}, {15'd0, (m_ovf & m_ctrl[1]) | (m_inf & m_ctrl[0])});
            chk("R11 irq_nc", {15'd0, irq_nc}, 16'd0);
            if (rd_en) chk(addr >= 2 ? "R9 count read vs model" : "R1 reg read vs model",
                           {8'd0, rdata}, {8'd0, m_read(addr)});
         end
      end
   end

   // ---------------- bus and pin tasks ----------------
   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      rd_en = 1; addr = a;
      #3 chk(req, {8'd0, rdata}, {8'd0, exp});
      @(posedge clk); #1;
      rd_en = 0;
   endtask

   task automatic rd_nc(logic [1:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      rd_en = 1; addr = a;
      #3 chk(req, {8'd0, rdata_nc}, {8'd0, exp});
      @(posedge clk); #1;
      rd_en = 0;
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pin = 1;
         repeat (4) @(negedge clk);
         pin = 0;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic hold(logic v, int n);
      @(negedge clk); pin = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      summary();
      $finish;
   end

   // ---------------- directed sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq reset", {15'd0, irq}, 16'd0);
      rd(2'd0, 8'h00, "R1 ctrl reset");
      rd(2'd1, 8'h00, "R1 flags reset");
      rd(2'd2, 8'h00, "R1 cnt hi reset");
      rd(2'd3, 8'h00, "R1 cnt lo reset");

      // R1 layout, R3 rising event
      wr(2'd0, 8'hDC);
      rd(2'd0, 8'h5C, "R1 ctrl bit7 reads 0, clksel kept");
      pulses(3);
      rd(2'd2, 8'h00, "R3 rising hi");
      rd(2'd3, 8'h03, "R3 rising count");
      rd(2'd1, 8'h01, "R5 input flag event");

      // R10 input irq, R7 clear, R3 falling
      wr(2'd0, 8'h41);
      chk("R10 irq on input flag", {15'd0, irq}, 16'd1);
      wr(2'd1, 8'h01);
      chk("R7 irq cleared by W1C", {15'd0, irq}, 16'd0);
      pulses(2);
      rd(2'd2, 8'h00, "R3 falling hi");
      rd(2'd3, 8'h05, "R3 falling count");
      chk("R10 irq after falling edge", {15'd0, irq}, 16'd1);
      wr(2'd1, 8'h03);

      // R2 disabled, mode set
      wr(2'd0, 8'h20);
      hold(1, 200);
      hold(0, 4);
      pulses(2);
      rd(2'd2, 8'h00, "R2 disabled hi");
      rd(2'd3, 8'h05, "R2 disabled count holds");
      rd(2'd1, 8'h00, "R2 disabled no flags");

      // R4 gated active-high, R5 trailing edge
      wr(2'd0, 8'h60);
      hold(0, 4);
      hold(1, 320);
      hold(0, 5);
      rd(2'd2, 8'h00, "R4 gated hi");
      rd(2'd3, 8'h0A, "R4 gated high 320 cycles");
      rd(2'd1, 8'h01, "R5 gated trailing edge flag");
      wr(2'd1, 8'h01);

      // R4 gated active-low
      hold(1, 4);
      wr(2'd0, 8'h70);
      hold(0, 128);
      hold(1, 5);
      rd(2'd2, 8'h00, "R4 gated low hi");
      rd(2'd3, 8'h0C, "R4 gated low 128 cycles");
      wr(2'd1, 8'h03);

      // R8 load, R6 overflow, R10 overflow irq
      wr(2'd0, 8'h52);
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'hFE);
      rd(2'd2, 8'hFF, "R8 loaded hi");
      rd(2'd3, 8'hFE, "R8 loaded lo");
      hold(0, 4);
      pulses(2);
      rd(2'd2, 8'h00, "R6 wrapped hi");
      rd(2'd3, 8'h00, "R6 wrapped lo");
      rd(2'd1, 8'h03, "R6 overflow flag");
      chk("R10 irq on overflow", {15'd0, irq}, 16'd1);

      // R9 coherent read
      wr(2'd2, 8'h12);
      wr(2'd3, 8'hFF);
      rd(2'd2, 8'h12, "R9 hi before edge");
      pulses(1);
      rd(2'd3, 8'hFF, "R9 lo is captured value");
      rd(2'd2, 8'h13, "R9 new hi");
      rd(2'd3, 8'h00, "R9 new lo");

      // R7 set and clear in the same cycle: overflow still set
      wr(2'd2, 8'hFF);
      wr(2'd3, 8'hFF);
      @(negedge clk); pin = 1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1; addr = 2'd1; wdata = 8'h02;
      @(posedge clk); #1; wr_en = 0;
      rd(2'd1, 8'h03, "R7 set wins over clear");
      rd(2'd2, 8'h00, "R6 same-cycle wrap hi");

      // R8 load and increment in the same cycle: load wins
      hold(0, 4);
      wr(2'd2, 8'h40);
      @(negedge clk); pin = 1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1; addr = 2'd3; wdata = 8'h00;
      @(posedge clk); #1; wr_en = 0;
      rd(2'd2, 8'h40, "R8 load wins hi");
      rd(2'd3, 8'h00, "R8 load wins lo");

      // R11 reserved control without channel 7
      rd_nc(2'd0, 8'h00, "R11 reserved ctrl reads 0");
      rd_nc(2'd1, 8'h00, "R11 no flags");
      rd_nc(2'd2, 8'h40, "R11 count hi only loaded");
      rd_nc(2'd3, 8'h00, "R11 count lo never counted");
      rd(2'd0, 8'h52, "R1 ctrl final");

      repeat (4) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule